// File: doc/BRIEF.md
# RC Pulse-Position Frame Encoder

This block builds the serial pulse-position stream that a radio-control transmitter sends to its RF stage. Each frame carries four channel values. A channel is coded as the distance between two separator pulses. The frame closes with a long sync slot, so that the frame period stays fixed no matter what the channel values are. All timing comes from a 1 µs tick enable.

A 16-bit tick counter runs freely from reset and is never reloaded. Each output edge is placed by a compare target. On every match the target moves forward by the length of the next interval, using modulo-2^16 addition. Because of this, frame spacing stays exact across counter rollover, and no error builds up from frame to frame. The channel inputs are captured at the start of each sync slot, so a frame that is already being sent never changes partway through.

Pulling the compare enable low stops the schedule and forces the output to its idle level. A new start strobe is then needed to begin again. A static polarity input picks whether the separator pulse is driven high or low. A one-cycle match pulse is produced together with every scheduled edge.

Top module: `ppm_frame_enc`

## Requirements
- R1: After reset, and until the first start strobe, ppm_o holds the idle level (the inverse of pulse_hi_i) and match_o stays 0.
- R2: After a start strobe, a frame begins with the sync slot and then carries channels 1 to 4 in order. Each slot starts with a transition to the pulse level (pulse level = pulse_hi_i), so a frame is 10 edges.
- R3: Every separator pulse lasts exactly 300 ticks.
- R4: The slot of channel k lasts 1000 + min(v, 1000) ticks, measured from its pulse start to the next pulse start. Here v is the unsigned 10-bit field ch_val_i[10(k-1)+9 : 10(k-1)], and channel 1 sits in bits 9:0.
- R5: The sync slot lasts 20000 ticks minus the sum of the four channel slots, so successive sync-slot starts are exactly 20000 ticks apart.
- R6: Channel values are captured only at the start of the sync slot. Changes made later in the frame do not affect that frame; they take effect in the next one.
- R7: Edge timing and the frame period are unaffected when the free-running 16-bit tick counter wraps.
- R8: A low cmp_en_i forces ppm_o to the idle level by the next cycle and stops all matches. Raising it again does not restart output without a new start strobe.
- R9: With pulse_hi_i = 0 the separator pulse is driven low and the idle level is high. With pulse_hi_i = 1 both are inverted.
- R10: match_o is a single-cycle pulse that comes in the same cycle as each scheduled ppm_o edge, and only then.
- R11: Time advances only on cycles with tick_i high. With a tick every second clock, every interval in clocks doubles.
- R12: A start strobe that arrives while a frame sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 µs time-base enable |
| cmp_en_i | input | 1 | Compare enable; low forces idle and stops the schedule |
| sof_i | input | 1 | Start strobe; arms the first sync slot when idle |
| pulse_hi_i | input | 1 | Separator pulse polarity: 1 = high pulse on low idle |
| ch_val_i | input | 40 | Four 10-bit channel values, channel 1 in bits 9:0 |
| ppm_o | output | 1 | Pulse-position output |
| match_o | output | 1 | One-cycle pulse with every scheduled edge |

## Verification
The assertions assume three things about the inputs. First, pulse_hi_i changes only while cmp_en_i is low. Second, tick_i is a plain enable, so the separator width in ticks can be counted from it. Third, the separator lasts at least one tick, which keeps matches apart. The edge-without-match property also treats a cycle that follows a low cmp_en_i as a permitted forced edge. The stimulus respects these assumptions. Polarity is switched only while the encoder is disabled. The tick runs either every cycle or every second cycle. The only edges produced outside the schedule come from the deliberate disable in the middle of a pulse.

// File: rtl/ppm_enc_pkg.sv
package ppm_enc_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;
endpackage

// File: rtl/ppm_timebase.sv
module ppm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] target_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  // free-running, never reloaded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign hit_o = run_i & tick_i & (cnt_q == target_i);
endmodule

// File: rtl/ppm_slot_calc.sv
module ppm_slot_calc #(
  parameter int NUM_CH      = 4,
  parameter int VAL_W       = 10,
  parameter int CNT_W       = 16,
  parameter int SLOT_MIN_T  = 1000,
  parameter int SLOT_SPAN_T = 1000,
  parameter int FRAME_T     = 20000
) (
  input  logic [NUM_CH-1:0][VAL_W-1:0] vals_i,
  output logic [NUM_CH-1:0][CNT_W-1:0] slot_o,
  output logic [CNT_W-1:0]             sync_o
);
  localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(SLOT_MIN_T);
  localparam logic [CNT_W-1:0] SPAN_C  = CNT_W'(SLOT_SPAN_T);
  localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(FRAME_T);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [CNT_W-1:0] v_ext;
    assign v_ext     = {{(CNT_W-VAL_W){1'b0}}, vals_i[g]};
    assign slot_o[g] = MIN_C + ((v_ext > SPAN_C) ? SPAN_C : v_ext);
  end

  logic [CNT_W-1:0] acc;
  always_comb begin
    acc = '0;
    for (int i = 0; i < NUM_CH; i++) acc = acc + slot_o[i];
    sync_o = FRAME_C - acc;
  end
endmodule

// File: rtl/ppm_sequencer.sv
module ppm_sequencer
  import ppm_enc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int SEP_T  = 300
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic                         sof_i,
  input  logic                         hit_i,
  input  logic [CNT_W-1:0]             cnt_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] slot_i,
  input  logic [CNT_W-1:0]             sync_i,
  output logic                         run_o,
  output logic [CNT_W-1:0]             target_o,
  output logic                         load_o,
  output logic                         pulse_o,
  output logic                         match_o
);
  localparam int PH_W = $clog2(NUM_CH + 1);
  localparam logic [CNT_W-1:0] SEP_C = CNT_W'(SEP_T);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(NUM_CH);

  logic             run_q, pulse_q, match_q;
  logic [CNT_W-1:0] target_q, gap;
  logic [PH_W-1:0]  ph_q;  // 0 = sync slot, k = channel k
  edge_e            nxt_q;

  always_comb begin
    gap = sync_i;
    for (int i = 0; i < NUM_CH; i++)
      if (ph_q == PH_W'(i + 1)) gap = slot_i[i];
    gap = gap - SEP_C;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      pulse_q  <= 1'b0;
      match_q  <= 1'b0;
      target_q <= '0;
      ph_q     <= '0;
      nxt_q    <= EDGE_RISE;
    end else if (!en_i) begin
      // disabled compare: latch back to default low
      run_q   <= 1'b0;
      pulse_q <= 1'b0;
      match_q <= 1'b0;
      ph_q    <= '0;
      nxt_q   <= EDGE_RISE;
    end else begin
      match_q <= hit_i;
      if (!run_q) begin
        if (sof_i) begin
          run_q    <= 1'b1;
          target_q <= cnt_i + 1'b1;
          ph_q     <= '0;
          nxt_q    <= EDGE_RISE;
        end
      end else if (hit_i) begin
        if (nxt_q == EDGE_RISE) begin
          pulse_q  <= 1'b1;
          target_q <= target_q + SEP_C;
          nxt_q    <= EDGE_FALL;
        end else begin
          pulse_q  <= 1'b0;
          target_q <= target_q + gap;
          nxt_q    <= EDGE_RISE;
          ph_q     <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
        end
      end
    end
  end

  assign run_o    = run_q;
  assign target_o = target_q;
  assign load_o   = hit_i & (nxt_q == EDGE_RISE) & (ph_q == '0);
  assign pulse_o  = pulse_q;
  assign match_o  = match_q;
endmodule

// File: rtl/ppm_frame_enc.sv
module ppm_frame_enc #(
  parameter int NUM_CH      = 4,
  parameter int VAL_W       = 10,
  parameter int CNT_W       = 16,
  parameter int SEP_T       = 300,
  parameter int SLOT_MIN_T  = 1000,
  parameter int SLOT_SPAN_T = 1000,
  parameter int FRAME_T     = 20000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    cmp_en_i,
  input  logic                    sof_i,
  input  logic                    pulse_hi_i,
  input  logic [NUM_CH*VAL_W-1:0] ch_val_i,
  output logic                    ppm_o,
  output logic                    match_o
);
  logic [NUM_CH-1:0][VAL_W-1:0] vals_q;
  logic [NUM_CH-1:0][CNT_W-1:0] slot;
  logic [CNT_W-1:0]             sync_len, cnt, target;
  logic                         run, hit, load, pulse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vals_q <= '0;
    else if (load) vals_q <= ch_val_i;
  end

  ppm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run_i    (run),
    .target_i (target),
    .cnt_o    (cnt),
    .hit_o    (hit)
  );

  ppm_slot_calc #(
    .NUM_CH(NUM_CH), .VAL_W(VAL_W), .CNT_W(CNT_W),
    .SLOT_MIN_T(SLOT_MIN_T), .SLOT_SPAN_T(SLOT_SPAN_T), .FRAME_T(FRAME_T)
  ) u_calc (
    .vals_i (vals_q),
    .slot_o (slot),
    .sync_o (sync_len)
  );

  ppm_sequencer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .SEP_T(SEP_T)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cmp_en_i),
    .sof_i    (sof_i),
    .hit_i    (hit),
    .cnt_i    (cnt),
    .slot_i   (slot),
    .sync_i   (sync_len),
    .run_o    (run),
    .target_o (target),
    .load_o   (load),
    .pulse_o  (pulse),
    .match_o  (match_o)
  );

  assign ppm_o = pulse_hi_i ? pulse : ~pulse;
endmodule

// File: rtl/ppm_frame_enc_chk.sv
module ppm_frame_enc_chk #(
  parameter int SEP_T = 300
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic cmp_en_i,
  input logic pulse_hi_i,
  input logic ppm_o,
  input logic match_o
);
  logic [31:0] pw_ticks;
  logic        in_pulse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pw_ticks <= '0;
      in_pulse <= 1'b0;
    end else if (!cmp_en_i) begin
      in_pulse <= 1'b0;
    end else if (match_o && (ppm_o == pulse_hi_i)) begin
      in_pulse <= 1'b1;
      pw_ticks <= tick_i ? 32'd1 : 32'd0;
    end else begin
      if (match_o) in_pulse <= 1'b0;
      if (tick_i)  pw_ticks <= pw_ticks + 32'd1;
    end
  end

  // R3
  p_sep_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && in_pulse && (ppm_o != pulse_hi_i)) |-> (pw_ticks == 32'(SEP_T)));

  // R8
  p_idle_when_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cmp_en_i) |-> ((ppm_o == !pulse_hi_i) && !match_o));

  // R10
  p_edge_has_match_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ppm_o != $past(ppm_o)) && $stable(pulse_hi_i) && $past(cmp_en_i)) |-> match_o);

  // R10
  p_match_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);

  // R11
  p_match_on_tick_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(tick_i));
endmodule

bind ppm_frame_enc ppm_frame_enc_chk #(.SEP_T(SEP_T)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .cmp_en_i   (cmp_en_i),
  .pulse_hi_i (pulse_hi_i),
  .ppm_o      (ppm_o),
  .match_o    (match_o)
);

// File: tb/ppm_frame_enc_tb_top.sv
module ppm_frame_enc_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        cmp_en_i = 1'b1;
  logic        sof_i = 1'b0;
  logic        pulse_hi_i = 1'b1;
  logic [39:0] ch_val_i = '0;
  logic        ppm_o, match_o;

  int n_chk = 0, n_fail = 0;
  int tick_div = 1;
  int cyc = 0, n_edge = 0, r10_bad = 0;
  int e_t [128];
  logic e_l [128];
  logic ppm_d = 1'b0, en_d = 1'b0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  ppm_frame_enc dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cmp_en_i(cmp_en_i),
    .sof_i(sof_i), .pulse_hi_i(pulse_hi_i), .ch_val_i(ch_val_i),
    .ppm_o(ppm_o), .match_o(match_o)
  );

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk_i);
      ph++;
      tick_i = ((ph % tick_div) == 0);
    end
  end

  // edge recorder
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (cmp_en_i && en_d) begin
        if (ppm_o != ppm_d) begin
          if (!match_o) r10_bad++;
          if (n_edge < 128) begin
            e_t[n_edge] = cyc;
            e_l[n_edge] = ppm_o;
          end
          n_edge++;
        end else if (match_o) r10_bad++;
      end
      ppm_d = ppm_o;
      en_d  = cmp_en_i;
      cyc++;
    end
  end

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int slot_of(input int v);
    return 1000 + ((v > 1000) ? 1000 : v);
  endfunction

  task automatic set_vals(input int a, input int b, input int c, input int d);
    @(negedge clk_i);
    ch_val_i = {10'(d), 10'(c), 10'(b), 10'(a)};
  endtask

  task automatic wait_edges(input int n);
    while (n_edge < n) @(negedge clk_i);
  endtask

  task automatic pulse_sof();
    @(negedge clk_i);
    sof_i = 1'b1;
    @(negedge clk_i);
    sof_i = 1'b0;
  endtask

  task automatic check_frame(input int f, input int a, input int b, input int c,
                             input int d, input int div, input logic pol, input string tag);
    int v[4];
    int bs, sum, bad_lv;
    v = '{a, b, c, d};
    bs = 10 * f;
    sum = 0;
    bad_lv = 0;
    for (int k = 0; k < 4; k++) sum += slot_of(v[k]);
    for (int k = 0; k <= 10; k++)
      if (e_l[bs+k] != (((k % 2) == 0) ? pol : !pol)) bad_lv++;
    chk_eq({"R2 levels ", tag}, bad_lv, 0);
    chk_eq({"R3 separator ", tag}, e_t[bs+1] - e_t[bs], 300 * div);
    chk_eq({"R5 sync ", tag}, e_t[bs+2] - e_t[bs], (20000 - sum) * div);
    for (int k = 1; k <= 4; k++)
      chk_eq({"R4 slot ", tag}, e_t[bs+2*k+2] - e_t[bs+2*k], slot_of(v[k-1]) * div);
    chk_eq({"R5 period ", tag}, e_t[bs+10] - e_t[bs], 20000 * div);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_eq("R1 idle level", int'(ppm_o), 0);
    chk_eq("R1 no match", int'(match_o), 0);
    repeat (40) @(negedge clk_i);
    chk_eq("R1 no edges before start", n_edge, 0);
  endtask

  task automatic t_frames();
    set_vals(0, 1000, 500, 250);
    n_edge = 0;
    pulse_sof();
    wait_edges(2);
    set_vals(1023, 700, 3, 999);      // mid-frame change
    wait_edges(11);
    set_vals(512, 512, 512, 512);
    wait_edges(21);
    set_vals(100, 200, 300, 400);
    wait_edges(31);
    set_vals(7, 7, 7, 7);
    wait_edges(41);
    check_frame(0, 0, 1000, 500, 250, 1, 1'b1, "R6 f0");
    check_frame(1, 1023, 700, 3, 999, 1, 1'b1, "R6 f1");
    check_frame(2, 512, 512, 512, 512, 1, 1'b1, "f2");
    check_frame(3, 100, 200, 300, 400, 1, 1'b1, "R7 wrap");
  endtask

  task automatic t_disable();
    int bad = 0;
    // still inside the sync separator pulse
    chk_eq("R8 pulse before disable", int'(ppm_o), 1);
    cmp_en_i = 1'b0;
    @(negedge clk_i);
    chk_eq("R8 forced idle", int'(ppm_o), 0);
    repeat (400) begin
      @(negedge clk_i);
      if (ppm_o || match_o) bad++;
    end
    cmp_en_i = 1'b1;
    repeat (600) begin
      @(negedge clk_i);
      if (ppm_o || match_o) bad++;
    end
    chk_eq("R8 quiet without restart", bad, 0);
  endtask

  task automatic t_polarity();
    cmp_en_i = 1'b0;
    @(negedge clk_i);
    pulse_hi_i = 1'b0;
    tick_div = 2;
    @(negedge clk_i);
    chk_eq("R9 idle high", int'(ppm_o), 1);
    cmp_en_i = 1'b1;
    set_vals(800, 50, 1000, 600);
    @(negedge clk_i);
    n_edge = 0;
    pulse_sof();
    wait_edges(4);
    pulse_sof();                      // must be ignored
    wait_edges(11);
    check_frame(0, 800, 50, 1000, 600, 2, 1'b0, "R9/R11/R12");
    chk_eq("R10 match per edge", r10_bad, 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_frames();
    t_disable();
    t_polarity();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule